// File: doc/BRIEF.md
# Register Rename Map with Free List

This block is the renaming stage of an out-of-order core. Each cycle it can take one instruction carrying two source register names and, optionally, one destination register name. It translates every architectural name into the physical location that holds that name's most recent value. Each destination write is given a fresh physical location. Because later writers never reuse a location that an older instruction still reads, write-after-read and write-after-write conflicts disappear. Read-after-write dependences are kept, because a reader is pointed at exactly the location its producer will fill.

Two structures hold the state. The first is a map table indexed by architectural name. The second is a circular FIFO of unused physical locations: allocation takes from the head and released locations join at the tail. When a destination is renamed, the location it previously mapped to is reported on `prev_phys`. An outside controller can then hand that location back through the release port once no reader needs it. This block does not decide when a location is safe to free, and it has no checkpoint or recovery.

All rename outputs are combinational from the current state and the instruction inputs. The map table and the free list update on the next rising clock edge.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural name k maps to physical location k for every k below NUM_ARCH. The free list holds locations NUM_ARCH up to NUM_PHYS-1, with NUM_ARCH at the head, in ascending order. `stall` is low.
- R2: Source lookups use the map as it stood before the current instruction. A source whose name equals the instruction's own destination name returns the old location, not the newly allocated one.
- R3: An accepted instruction with `dst_en`=1 receives the free-list head on `dst_phys` in the same cycle. From the next cycle on, its destination name maps to that location, and the location is never the one shown on `prev_phys`.
- R4: For an accepted destination write, `prev_phys` shows the location the destination name mapped to before this instruction.
- R5: An instruction with `dst_en`=0 takes no location from the free list and leaves the map table unchanged. The next destination write still receives the same head location.
- R6: The free list is first-in first-out. Locations released through `rel_valid`/`rel_phys` are allocated after every location already in the list, in the order they were released. A release takes effect at the next clock edge.
- R7: When `in_valid`=1, `dst_en`=1 and the free list is empty, `stall` is high and `out_valid` is low. No location is allocated and the map table is not changed. Otherwise `out_valid` equals `in_valid` and `stall` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| dst_en | input | 1 | The instruction writes a destination register |
| src_a_arch | input | $clog2(NUM_ARCH) | First source architectural name |
| src_b_arch | input | $clog2(NUM_ARCH) | Second source architectural name |
| dst_arch | input | $clog2(NUM_ARCH) | Destination architectural name |
| rel_valid | input | 1 | Return one physical location to the free list |
| rel_phys | input | $clog2(NUM_PHYS) | Location being returned |
| src_a_phys | output | $clog2(NUM_PHYS) | Renamed first source |
| src_b_phys | output | $clog2(NUM_PHYS) | Renamed second source |
| dst_phys | output | $clog2(NUM_PHYS) | Newly allocated destination location |
| prev_phys | output | $clog2(NUM_PHYS) | Location the destination name held before this instruction |
| out_valid | output | 1 | The instruction is accepted this cycle |
| stall | output | 1 | The instruction is held for lack of a free location |

## Verification
The bench goes after the read-before-remap case, where an instruction names the same register as source and destination. A design that forwarded the new allocation would hand that source its own destination location, and the check on `src_a_phys` would catch it. It renames the same name twice in a row. A stale map write would show up as a wrong `prev_phys` on the second rename, or as a reused location. It sends instructions with no destination between writes. A design that consumed a location regardless of `dst_en` would hand the next writer a skipped location. Finally, it drains the free list to empty and checks three things: that stall blocks any map change, that released locations come back in release order, and that a lost tail pointer or count would cause the wrong location or a stall where none is expected.

// File: rtl/rename_pkg.sv
package rename_pkg;

  // Location stored in free-list slot `slot` right after reset.
  function automatic int init_loc(int slot, int narch);
    return narch + slot;
  endfunction

  // Occupancy after one cycle of optional pop and optional push.
  function automatic int count_next(int cur, bit pop, bit push);
    return cur + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_b_idx,
  input  logic [AW-1:0] rd_d_idx,
  output logic [PW-1:0] rd_a_loc,
  output logic [PW-1:0] rd_b_loc,
  output logic [PW-1:0] rd_d_loc,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [PW-1:0] wr_loc
);

  logic [PW-1:0] ent [NUM_ARCH];

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent[g] <= PW'(g);
      else if (wr_en && wr_idx == AW'(g))
        ent[g] <= wr_loc;
    end
  end

  // Reads see the registered state, i.e. the map before this cycle's write.
  assign rd_a_loc = ent[rd_a_idx];
  assign rd_b_loc = ent[rd_b_idx];
  assign rd_d_loc = ent[rd_d_idx];

endmodule

// File: rtl/rename_free_list.sv
module rename_free_list
  import rename_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_loc,
  output logic [PW-1:0] head_loc,
  output logic          empty,
  output logic [CW-1:0] count
);

  logic [PW-1:0] slots [NUM_PHYS];
  logic [PW-1:0] head_q, tail_q;
  logic          full;
  logic          do_pop, do_push;

  assign empty    = (count == '0);
  assign full     = (count == CW'(NUM_PHYS));
  assign do_pop   = pop && !empty;
  assign do_push  = push && !full;
  assign head_loc = slots[head_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++)
        slots[i] <= PW'(init_loc(i, NUM_ARCH));
      head_q <= '0;
      tail_q <= PW'(NUM_PHYS - NUM_ARCH);
      count  <= CW'(NUM_PHYS - NUM_ARCH);
    end else begin
      if (do_push) begin
        slots[tail_q] <= push_loc;
        tail_q        <= tail_q + PW'(1);
      end
      if (do_pop)
        head_q <= head_q + PW'(1);
      count <= CW'(count_next(int'(count), do_pop, do_push));
    end
  end

endmodule

// File: rtl/rename_map.sv
module rename_map #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          dst_en,
  input  logic [AW-1:0] src_a_arch,
  input  logic [AW-1:0] src_b_arch,
  input  logic [AW-1:0] dst_arch,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_phys,
  output logic [PW-1:0] src_a_phys,
  output logic [PW-1:0] src_b_phys,
  output logic [PW-1:0] dst_phys,
  output logic [PW-1:0] prev_phys,
  output logic          out_valid,
  output logic          stall
);

  // Internal events, named for the checker.
  logic          alloc_fire;
  logic          fl_empty;
  logic [CW-1:0] fl_count;
  logic [PW-1:0] fl_head;

  assign stall      = in_valid && dst_en && fl_empty;
  assign out_valid  = in_valid && !stall;
  assign alloc_fire = out_valid && dst_en;
  assign dst_phys   = fl_head;

  rename_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (src_a_arch),
    .rd_b_idx (src_b_arch),
    .rd_d_idx (dst_arch),
    .rd_a_loc (src_a_phys),
    .rd_b_loc (src_b_phys),
    .rd_d_loc (prev_phys),
    .wr_en    (alloc_fire),
    .wr_idx   (dst_arch),
    .wr_loc   (fl_head)
  );

  rename_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (alloc_fire),
    .push     (rel_valid),
    .push_loc (rel_phys),
    .head_loc (fl_head),
    .empty    (fl_empty),
    .count    (fl_count)
  );

endmodule

// File: rtl/rename_map_chk.sv
module rename_map_chk #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          dst_en,
  input logic [AW-1:0] src_a_arch,
  input logic [AW-1:0] dst_arch,
  input logic [PW-1:0] src_a_phys,
  input logic [PW-1:0] dst_phys,
  input logic [PW-1:0] prev_phys,
  input logic          out_valid,
  input logic          stall,
  input logic          rel_valid,
  input logic          alloc_fire,
  input logic          fl_empty,
  input logic [CW-1:0] fl_count
);

  // R7
  stall_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!alloc_fire && !out_valid && fl_empty));

  // R7
  stall_needs_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dst_en) |-> !stall);

  // R3
  alloc_takes_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && !rel_valid) |=> (fl_count == $past(fl_count) - CW'(1)));

  // R3
  fresh_location_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> (dst_phys != prev_phys));

  // R6
  release_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !alloc_fire && fl_count != CW'(NUM_PHYS)) |=>
      (fl_count == $past(fl_count) + CW'(1)));

  // R5
  no_dst_keeps_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dst_en && !rel_valid) |=> $stable(fl_count));

  // R2
  old_map_for_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && src_a_arch == dst_arch) |-> (src_a_phys == prev_phys));

endmodule

bind rename_map rename_map_chk #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .dst_en     (dst_en),
  .src_a_arch (src_a_arch),
  .dst_arch   (dst_arch),
  .src_a_phys (src_a_phys),
  .dst_phys   (dst_phys),
  .prev_phys  (prev_phys),
  .out_valid  (out_valid),
  .stall      (stall),
  .rel_valid  (rel_valid),
  .alloc_fire (alloc_fire),
  .fl_empty   (fl_empty),
  .fl_count   (fl_count)
);

// File: tb/tb_rename_map.sv
module tb_rename_map;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_ARCH = 8;
  localparam int NUM_PHYS = 16;
  localparam int AW = $clog2(NUM_ARCH);
  localparam int PW = $clog2(NUM_PHYS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          dst_en = 1'b0;
  logic [AW-1:0] src_a_arch = '0;
  logic [AW-1:0] src_b_arch = '0;
  logic [AW-1:0] dst_arch = '0;
  logic          rel_valid = 1'b0;
  logic [PW-1:0] rel_phys = '0;
  logic [PW-1:0] src_a_phys, src_b_phys, dst_phys, prev_phys;
  logic          out_valid, stall;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // Independent model: the map as an array, the free list as a queue.
  int map_m [NUM_ARCH];
  int fq [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  rename_map #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_en(dst_en),
    .src_a_arch(src_a_arch), .src_b_arch(src_b_arch), .dst_arch(dst_arch),
    .rel_valid(rel_valid), .rel_phys(rel_phys),
    .src_a_phys(src_a_phys), .src_b_phys(src_b_phys), .dst_phys(dst_phys),
    .prev_phys(prev_phys), .out_valid(out_valid), .stall(stall)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One instruction: drive at the falling edge, check, commit on the rising edge.
  task automatic do_rename(string req, bit de, int a, int b, int d);
    bit exp_stall;
    @(negedge clk);
    in_valid = 1'b1; dst_en = de;
    src_a_arch = AW'(a); src_b_arch = AW'(b); dst_arch = AW'(d);
    #1;
    exp_stall = de && (fq.size() == 0);
    chk({req, " stall"}, int'(stall), int'(exp_stall));
    chk({req, " out_valid"}, int'(out_valid), int'(!exp_stall));
    chk({req, " src_a"}, int'(src_a_phys), map_m[a]);
    chk({req, " src_b"}, int'(src_b_phys), map_m[b]);
    if (de && !exp_stall) begin
      chk({req, " dst"}, int'(dst_phys), fq[0]);
      chk({req, " prev"}, int'(prev_phys), map_m[d]);
    end
    @(posedge clk);
    if (de && !exp_stall) map_m[d] = fq.pop_front();
    #1 in_valid = 1'b0; dst_en = 1'b0;
  endtask

  task automatic do_release(int p);
    @(negedge clk);
    rel_valid = 1'b1; rel_phys = PW'(p);
    @(posedge clk);
    if (fq.size() < NUM_PHYS) fq.push_back(p);
    #1 rel_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 stall after reset", int'(stall), 0);
    for (int k = 0; k < NUM_ARCH; k++) begin
      src_a_arch = AW'(k); #1;
      chk("R1 identity map", int'(src_a_phys), k);
    end
    dst_en = 1'b1; #1;
    chk("R1 free head", int'(dst_phys), NUM_ARCH);
    dst_en = 1'b0;
  endtask

  task automatic t_basic();
    do_rename("R3 first write", 1, 2, 3, 1);
    do_rename("R4 rewrite same name", 1, 1, 2, 1);
    do_rename("R3 read new mapping", 0, 1, 1, 0);
  endtask

  task automatic t_same_cycle();
    do_rename("R2 source equals destination", 1, 5, 5, 5);
    do_rename("R2 follow-up read", 0, 5, 4, 0);
  endtask

  task automatic t_no_dst();
    do_rename("R5 no destination", 0, 6, 7, 6);
    do_rename("R5 map unchanged", 0, 6, 6, 0);
    do_rename("R5 head kept", 1, 0, 6, 6);
  endtask

  task automatic t_exhaust();
    for (int i = 0; fq.size() > 0 && i < NUM_PHYS; i++)
      do_rename("R3 drain", 1, i % NUM_ARCH, 3, i % NUM_ARCH);
    do_rename("R7 stall when empty", 1, 2, 3, 2);
    do_rename("R7 map kept after stall", 0, 2, 2, 0);
    do_rename("R7 no-dest passes when empty", 0, 4, 1, 0);
    do_release(3);
    do_rename("R6 released location reused", 1, 2, 3, 2);
    do_release(12);
    do_release(5);
    do_rename("R6 order first", 1, 0, 1, 7);
    do_rename("R6 order second", 1, 7, 1, 0);
    do_rename("R7 empty again", 1, 1, 1, 1);
  endtask

  initial begin
    for (int k = 0; k < NUM_ARCH; k++) map_m[k] = k;
    for (int p = NUM_ARCH; p < NUM_PHYS; p++) fq.push_back(p);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_same_cycle();
    t_no_dst();
    t_exhaust();
    repeat (2) @(posedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule